// File: doc/BRIEF.md
# Atomic Reservation Monitor

This block holds the single reservation that one hart needs for lock-free read-modify-write sequences. It decodes each memory operation's 6-bit opcode. A locked load arms a flag and remembers which 16-byte block it touched. A conditional store then commits to memory only while that flag is still armed. The outcome of the conditional store goes back into its own data register as a 0/1 value. The conditional store always disarms the reservation, whether it succeeds or fails.

The reservation can also be lost before the conditional store arrives. An ordinary store from the same hart to the reserved block drops it. So does an external invalidate strobe, which stands for a conflicting write from another agent. Load data is formatted on the writeback port: 32-bit loads are sign-extended and 64-bit loads pass through. All outputs are combinational from the current operation and the stored reservation. The reservation itself updates on the rising clock edge.

Top module: `llsc_monitor`

## Requirements
- R1: Opcode decode (active only while `op_valid` is 1). Locked loads are 0x2A (32-bit) and 0x2B (64-bit). Conditional stores are 0x2E (32-bit) and 0x2F (64-bit). Plain loads are 0x28 (32-bit) and 0x29 (64-bit). Plain stores are 0x2C (32-bit) and 0x2D (64-bit). The unaligned quad load is 0x0B and the unaligned quad store is 0x0F. Any other opcode, or `op_valid` = 0, writes nothing and leaves the reservation unchanged.
- R2: A locked load arms the reservation and records its address divided by 16 (bits above bit 3).
- R3: Every load asserts `wb_en` in the same cycle. A 32-bit load returns `mem_rdata[31:0]` sign-extended to 64 bits. A 64-bit load returns `mem_rdata` unchanged.
- R4: A conditional store asserts `mem_we` only while the reservation is armed. For the 32-bit form, `mem_be` = 0x0F and `mem_wdata` = `op_wdata` with bits 63:32 cleared. For the 64-bit form, `mem_be` = 0xFF.
- R5: A conditional store asserts `wb_en`. `wb_data` is 1 if the reservation was armed before the store and 0 if not, with bits 63:1 always zero.
- R6: Every conditional store disarms the reservation, whether it succeeds or fails.
- R7: A plain store, or an asserted `inval_en`, disarms the reservation if its address lies in the reserved 16-byte block. An address in any other block leaves the reservation armed.
- R8: A new locked load replaces the recorded block and arms the reservation again. A same-cycle invalidate does not cancel the new reservation.
- R9: After reset the reservation is disarmed, so a conditional store with no prior locked load fails.
- R10: The unaligned quad forms (0x0B, 0x0F) clear `mem_addr[2:0]`. All other operations pass `op_addr` through to `mem_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 6 | Major opcode of the operation |
| op_addr | input | ADDR_W | Physical byte address |
| op_wdata | input | 64 | Source register value for stores |
| mem_rdata | input | 64 | Data returned by memory for loads |
| inval_en | input | 1 | Conflicting write by another agent |
| inval_addr | input | ADDR_W | Address of that conflicting write |
| mem_we | output | 1 | Store enable toward memory |
| mem_addr | output | ADDR_W | Address toward memory |
| mem_be | output | 8 | Byte enables of the store |
| mem_wdata | output | 64 | Store data toward memory |
| wb_en | output | 1 | Register writeback enable |
| wb_data | output | 64 | Register writeback value |

## Verification
A table of operations tries conditional stores in several situations: with no prior locked load, right after one, a second time, and after a store to the same block or to a different block. It also covers invalidates that hit or miss the block, a same-cycle invalidate on a locked load, and a replaced reservation. Each situation tells apart whether the flag is cleared, by which event, and at which block granularity. Load data uses values with bit 31 set and clear, which separates sign extension from zero extension. Directed tests cover byte enables, upper-data clearing, unaligned address masking, gating by `op_valid`, and a reset in the middle of a reservation.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int ADDR_W    = 40,
  parameter int GRAN_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [5:0]        op_code,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [63:0]       op_wdata,
  input  logic [63:0]       mem_rdata,
  input  logic              inval_en,
  input  logic [ADDR_W-1:0] inval_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_be,
  output logic [63:0]       mem_wdata,
  output logic              wb_en,
  output logic [63:0]       wb_data
);
  localparam int BLK_W = ADDR_W - GRAN_LOG2;

  logic             lock_flag;
  logic [BLK_W-1:0] lock_blk;

  logic is_ll, is_sc, is_ld, is_st, is_unal, narrow;
  assign is_ll   = op_valid && (op_code == 6'h2A || op_code == 6'h2B);
  assign is_sc   = op_valid && (op_code == 6'h2E || op_code == 6'h2F);
  assign is_unal = op_valid && (op_code == 6'h0B || op_code == 6'h0F);
  assign is_ld   = is_ll || (op_valid && (op_code == 6'h28 || op_code == 6'h29 || op_code == 6'h0B));
  assign is_st   = op_valid && (op_code == 6'h2C || op_code == 6'h2D || op_code == 6'h0F);
  assign narrow  = ~op_code[0];

  logic [BLK_W-1:0] op_blk, inv_blk;
  assign op_blk  = op_addr[ADDR_W-1:GRAN_LOG2];
  assign inv_blk = inval_addr[ADDR_W-1:GRAN_LOG2];

  assign mem_we    = is_st || (is_sc && lock_flag);
  assign mem_addr  = is_unal ? {op_addr[ADDR_W-1:3], 3'b000} : op_addr;
  assign mem_be    = narrow ? 8'h0F : 8'hFF;
  assign mem_wdata = narrow ? {32'h0, op_wdata[31:0]} : op_wdata;

  assign wb_en = is_ld || is_sc;
  always_comb begin
    wb_data = '0;
    if (is_sc)
      wb_data = {63'h0, lock_flag};
    else if (is_ld)
      wb_data = narrow ? {{32{mem_rdata[31]}}, mem_rdata[31:0]} : mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_flag <= 1'b0;
      lock_blk  <= '0;
    end else if (is_ll) begin
      lock_flag <= 1'b1;
      lock_blk  <= op_blk;
    end else if (is_sc || (is_st && op_blk == lock_blk) ||
                 (inval_en && inv_blk == lock_blk)) begin
      lock_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int ADDR_W    = 40,
  parameter int GRAN_LOG2 = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [5:0]        op_code,
  input logic [ADDR_W-1:0] op_addr,
  input logic              inval_en,
  input logic [ADDR_W-1:0] inval_addr,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_be,
  input logic              wb_en,
  input logic [63:0]       wb_data,
  input logic              lock_flag,
  input logic [ADDR_W-GRAN_LOG2-1:0] lock_blk
);
  logic ll, sc, ld32, unal;
  assign ll   = op_valid && (op_code == 6'h2A || op_code == 6'h2B);
  assign sc   = op_valid && (op_code == 6'h2E || op_code == 6'h2F);
  assign ld32 = op_valid && (op_code == 6'h28 || op_code == 6'h2A);
  assign unal = op_valid && (op_code == 6'h0B || op_code == 6'h0F);

  // R2
  ll_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ll |=> lock_flag && lock_blk == $past(op_addr[ADDR_W-1:GRAN_LOG2]));
  // R5
  sc_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc |-> wb_en && wb_data[63:1] == '0 && wb_data[0] == mem_we);
  // R6
  sc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc |=> !lock_flag);
  // R4
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_be == 8'h0F || mem_be == 8'hFF));
  // R3
  ld_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld32 |-> wb_en && wb_data[63:32] == {32{wb_data[31]}});
  // R10
  unal_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unal |-> mem_addr[2:0] == 3'b000);
  // R7
  inval_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval_en && !ll && inval_addr[ADDR_W-1:GRAN_LOG2] == lock_blk |=> !lock_flag);
endmodule

bind llsc_monitor llsc_monitor_chk #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .op_addr(op_addr), .inval_en(inval_en), .inval_addr(inval_addr),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .wb_en(wb_en),
  .wb_data(wb_data), .lock_flag(lock_flag), .lock_blk(lock_blk));

// File: tb/llsc_monitor_tb_top.sv
module llsc_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [5:0]  op_code = '0;
  logic [39:0] op_addr = '0;
  logic [63:0] op_wdata = '0;
  logic [63:0] mem_rdata = '0;
  logic        inval_en = 1'b0;
  logic [39:0] inval_addr = '0;
  logic        mem_we, wb_en;
  logic [39:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata, wb_data;
  int errs = 0, total = 0;
  bit done = 0;

  always #4 clk = ~clk;

  llsc_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_addr(op_addr), .op_wdata(op_wdata), .mem_rdata(mem_rdata),
    .inval_en(inval_en), .inval_addr(inval_addr), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .wb_en(wb_en), .wb_data(wb_data));

  typedef struct packed {
    logic [5:0]  op;
    logic [39:0] addr;
    logic [63:0] wd;
    logic [63:0] rd;
    logic        inv;
    logic [39:0] iaddr;
    logic        we;
    logic        wbe;
    logic [63:0] wb;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{6'h2F, 40'h100, 64'h5, 64'h0, 1'b0, 40'h0, 1'b0, 1'b1, 64'h0},                  // R9 R5 no reservation
    '{6'h2B, 40'h100, 64'h0, 64'h1122334455667788, 1'b0, 40'h0, 1'b0, 1'b1, 64'h1122334455667788}, // R2 R3
    '{6'h2F, 40'h100, 64'h9, 64'h0, 1'b0, 40'h0, 1'b1, 1'b1, 64'h1},                  // R4 R5 success
    '{6'h2F, 40'h100, 64'h9, 64'h0, 1'b0, 40'h0, 1'b0, 1'b1, 64'h0},                  // R6 cleared
    '{6'h2A, 40'h200, 64'h0, 64'h0000000080000001, 1'b0, 40'h0, 1'b0, 1'b1, 64'hFFFFFFFF80000001}, // R3 sext
    '{6'h2D, 40'h20C, 64'h7, 64'h0, 1'b0, 40'h0, 1'b1, 1'b0, 64'h0},                  // R7 own store hit
    '{6'h2E, 40'h200, 64'h7, 64'h0, 1'b0, 40'h0, 1'b0, 1'b1, 64'h0},                  // R7 fails
    '{6'h2A, 40'h300, 64'h0, 64'hDEAD00007FFFFFFF, 1'b0, 40'h0, 1'b0, 1'b1, 64'h000000007FFFFFFF}, // R3 positive
    '{6'h2C, 40'h310, 64'h3, 64'h0, 1'b0, 40'h0, 1'b1, 1'b0, 64'h0},                  // R7 other block
    '{6'h2E, 40'h300, 64'h3, 64'h0, 1'b0, 40'h0, 1'b1, 1'b1, 64'h1},                  // R7 still armed
    '{6'h2B, 40'h400, 64'h0, 64'h42, 1'b1, 40'h408, 1'b0, 1'b1, 64'h42},              // R8 inval same cycle
    '{6'h2F, 40'h400, 64'h1, 64'h0, 1'b0, 40'h0, 1'b1, 1'b1, 64'h1},                  // R8 LL wins
    '{6'h2B, 40'h500, 64'h0, 64'h55, 1'b0, 40'h0, 1'b0, 1'b1, 64'h55},                // R2
    '{6'h2B, 40'h600, 64'h0, 64'h66, 1'b0, 40'h0, 1'b0, 1'b1, 64'h66},                // R8 replace
    '{6'h2D, 40'h500, 64'h2, 64'h0, 1'b0, 40'h0, 1'b1, 1'b0, 64'h0},                  // R8 old block store
    '{6'h2F, 40'h600, 64'h2, 64'h0, 1'b0, 40'h0, 1'b1, 1'b1, 64'h1},                  // R8 new block kept
    '{6'h2B, 40'h700, 64'h0, 64'h77, 1'b0, 40'h0, 1'b0, 1'b1, 64'h77},                // R2
    '{6'h00, 40'h700, 64'h1, 64'h0, 1'b1, 40'h70F, 1'b0, 1'b0, 64'h0},                // R1 R7 unknown op, inval hit
    '{6'h2F, 40'h700, 64'h1, 64'h0, 1'b0, 40'h0, 1'b0, 1'b1, 64'h0},                  // R7 invalidated
    '{6'h28, 40'h800, 64'h0, 64'h00000000FFFF0000, 1'b0, 40'h0, 1'b0, 1'b1, 64'hFFFFFFFFFFFF0000} // R3 R1 plain load
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [5:0] op, input logic [39:0] a,
                       input logic [63:0] wd, input logic [63:0] rd,
                       input logic inv, input logic [39:0] ia);
    @(negedge clk);
    op_valid = v; op_code = op; op_addr = a; op_wdata = wd; mem_rdata = rd;
    inval_en = inv; inval_addr = ia;
    #2;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R9 idle outputs after reset
    chk("R9 idle", {126'h0, mem_we, wb_en}, 128'h0);

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i].op, VEC[i].addr, VEC[i].wd, VEC[i].rd, VEC[i].inv, VEC[i].iaddr);
      chk($sformatf("R1-table vector %0d", i), {62'h0, mem_we, wb_en, wb_data},
          {62'h0, VEC[i].we, VEC[i].wbe, VEC[i].wb});
    end

    // R4 narrow conditional store shape
    drive(1'b1, 6'h2A, 40'h900, 64'h0, 64'h0, 1'b0, 40'h0);
    drive(1'b1, 6'h2E, 40'h900, 64'hAAAABBBBCCCCDDDD, 64'h0, 1'b0, 40'h0);
    chk("R4 narrow", {55'h0, mem_we, mem_be, mem_wdata}, {55'h0, 1'b1, 8'h0F, 64'h00000000CCCCDDDD});
    // R4 wide conditional store shape
    drive(1'b1, 6'h2B, 40'h900, 64'h0, 64'h0, 1'b0, 40'h0);
    drive(1'b1, 6'h2F, 40'h900, 64'hAAAABBBBCCCCDDDD, 64'h0, 1'b0, 40'h0);
    chk("R4 wide", {55'h0, mem_we, mem_be, mem_wdata}, {55'h0, 1'b1, 8'hFF, 64'hAAAABBBBCCCCDDDD});

    // R10 unaligned store and load
    drive(1'b1, 6'h0F, 40'h80B, 64'h1234, 64'h0, 1'b0, 40'h0);
    chk("R10 store addr", {79'h0, mem_we, mem_be, mem_addr}, {79'h0, 1'b1, 8'hFF, 40'h808});
    drive(1'b1, 6'h0B, 40'h80D, 64'h0, 64'h8000000080000000, 1'b0, 40'h0);
    chk("R10 load addr", {87'h0, mem_addr}, {87'h0, 40'h808});
    chk("R3 unaligned load data", {63'h0, wb_en, wb_data}, {63'h0, 1'b1, 64'h8000000080000000});
    drive(1'b1, 6'h2D, 40'h80B, 64'h1234, 64'h0, 1'b0, 40'h0);
    chk("R10 aligned passthrough", {87'h0, mem_addr}, {87'h0, 40'h80B});

    // R1 op_valid low leaves reservation and writes nothing
    drive(1'b1, 6'h2B, 40'hB00, 64'h0, 64'h0, 1'b0, 40'h0);
    drive(1'b0, 6'h2F, 40'hB00, 64'h1, 64'h0, 1'b0, 40'h0);
    chk("R1 gated", {126'h0, mem_we, wb_en}, 128'h0);
    drive(1'b1, 6'h2F, 40'hB00, 64'h1, 64'h0, 1'b0, 40'h0);
    chk("R1 reservation kept", {63'h0, mem_we, wb_data}, {63'h0, 1'b1, 64'h1});

    // R9 reset in the middle of a reservation
    drive(1'b1, 6'h2B, 40'hA00, 64'h0, 64'h0, 1'b0, 40'h0);
    @(negedge clk);
    op_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 6'h2F, 40'hA00, 64'h1, 64'h0, 1'b0, 40'h0);
    chk("R9 reset drops reservation", {63'h0, mem_we, wb_data}, {63'h0, 1'b0, 64'h0});

    @(negedge clk);
    op_valid = 1'b0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule